// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Transmitter

This block is the target end of a one-wire, open-drain debug link, and it sends a single data bit back to the host. Logic that sits above it presents the bit on `bit_i` and pulses `load_i`, and the block then waits. The host owns the start of every bit time: it pulls the shared line low. The target finishes the bit. It counts from the falling edge it sees and either leaves the line floating (a one) or holds it low until after the host's sampling point (a zero). In both cases it then drives the line high for one cycle so that the rising edge is fast, and lets go.

The line input is asynchronous, so it passes through a two-stage synchronizer before the falling edge is detected. While a bit is in flight, further falling edges and load strobes have no effect. A single-cycle `done_o` closes each bit, and only after that can the next bit be loaded.

Top module: `sdbg_tx`

## Requirements
- R1: Reset leaves `line_oe_o`, `busy_o` and `done_o` at 0.
- R2: A `load_i` pulse while idle captures `bit_i` (1 means logic one) and raises `busy_o` from the next cycle. A `load_i` that arrives while `busy_o` or `done_o` is 1 changes nothing.
- R3: The line is registered twice. If the first clock edge at which `line_i` is low is edge k, then the bit time counter reads cycle 0 in the cycle after edge k+2. Until then the line is not driven.
- R4: For a logic one the line floats (`line_oe_o`=0) in cycles 0 to 6. In cycle 7 it is driven high (`line_oe_o`=1, `line_level_o`=1).
- R5: For a logic zero the line is driven low (`line_oe_o`=1, `line_level_o`=0) in cycles 0 to 12, which covers the host sampling point at cycle 10. In cycle 13 it is driven high.
- R6: In the cycle after the high pulse, `done_o` is 1 for exactly one cycle and `busy_o` is 0. `busy_o` stays 1 from the cycle after the load through the pulse cycle.
- R7: A falling edge on the line while no bit is loaded, or while a bit time is running, does not drive the line and does not change the timing of the running bit.
- R8: The high speed-up pulse lasts exactly one cycle, and the line is released in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Sensed level of the shared debug line |
| load_i | input | 1 | Strobe that accepts `bit_i` while idle |
| bit_i | input | 1 | Bit to send, 1 = logic one |
| line_oe_o | output | 1 | 1 = the target drives the line |
| line_level_o | output | 1 | Level driven when `line_oe_o` is 1 |
| busy_o | output | 1 | A bit is loaded or in flight |
| done_o | output | 1 | One-cycle pulse when the bit completes |

## Verification
Each output is due a fixed number of edges after its stimulus. `busy_o` follows the edge that samples `load_i`. Cycle 0 of the bit time starts three edges after the host's falling edge is first sampled. The pulse lands 7 or 13 cycles later, and `done_o` follows one cycle after the pulse. The driver pushes one expected record per clock into a queue at the moment it applies a stimulus. The monitor pops one record 3 ns after every rising edge, so every comparison falls in a known cycle. Mid-run edges and loads are injected without adding any record, which means any disturbance they cause appears as a mismatch in the trace that was already queued.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } sdbg_state_e;

endpackage

// File: rtl/sdbg_sync.sv
module sdbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign fall_o = prev_q & ~chain_q[STAGES-1];

    // R3: the edge pulse never lasts longer than one cycle
    assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/sdbg_drive.sv
module sdbg_drive #(
    parameter int ONE_PULSE_AT = 7,
    parameter int ZERO_LOW     = 13,
    parameter int CNT_W        = 4
) (
    input  logic             active_i,
    input  logic             bit_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             oe_o,
    output logic             level_o,
    output logic             last_o
);
    logic [CNT_W-1:0] pulse_at;
    logic             at_pulse;

    always_comb begin
        pulse_at = bit_i ? CNT_W'(ONE_PULSE_AT) : CNT_W'(ZERO_LOW);
        at_pulse = active_i && (cnt_i == pulse_at);
        oe_o     = at_pulse || (active_i && !bit_i && (cnt_i < pulse_at));
        level_o  = at_pulse;
        last_o   = at_pulse;
    end
endmodule

// File: rtl/sdbg_tx.sv
module sdbg_tx #(
    parameter int SYNC_STAGES  = 2,
    parameter int ONE_PULSE_AT = 7,
    parameter int ZERO_LOW     = 13,
    parameter int HOST_SAMPLE  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic load_i,
    input  logic bit_i,
    output logic line_oe_o,
    output logic line_level_o,
    output logic busy_o,
    output logic done_o
);
    import sdbg_pkg::*;

    localparam int MAX_CNT = (ZERO_LOW > ONE_PULSE_AT) ? ZERO_LOW : ONE_PULSE_AT;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    typedef struct packed {
        sdbg_state_e      state;
        logic             bit_val;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t r_q, r_d;
    logic  fall;
    logic  last;
    logic  run;

    sdbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .fall_o (fall)
    );

    assign run = (r_q.state == ST_RUN);

    sdbg_drive #(
        .ONE_PULSE_AT (ONE_PULSE_AT),
        .ZERO_LOW     (ZERO_LOW),
        .CNT_W        (CNT_W)
    ) u_drive (
        .active_i (run),
        .bit_i    (r_q.bit_val),
        .cnt_i    (r_q.cnt),
        .oe_o     (line_oe_o),
        .level_o  (line_level_o),
        .last_o   (last)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (load_i) begin
                    r_d.state   = ST_ARMED;
                    r_d.bit_val = bit_i;
                end
            end
            ST_ARMED: begin
                if (fall) begin
                    r_d.state = ST_RUN;
                    r_d.cnt   = '0;
                end
            end
            ST_RUN: begin
                if (last) begin
                    r_d.state = ST_DONE;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, bit_val: 1'b0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.state == ST_ARMED) || run;
    assign done_o = (r_q.state == ST_DONE);

    assert_load_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (busy_o || done_o)) |=> $stable(r_q.bit_val));

    assert_one_never_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && r_q.bit_val) |-> !(line_oe_o && !line_level_o));

    assert_zero_low_at_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !r_q.bit_val && r_q.cnt == CNT_W'(HOST_SAMPLE)) |-> (line_oe_o && !line_level_o));

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!busy_o && $past(busy_o)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !line_oe_o);

    assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe_o && line_level_o) |=> !line_oe_o);
endmodule

// File: tb/sdbg_tx_bench.sv
module sdbg_tx_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b0;
    logic load = 1'b0;
    logic bitv = 1'b0;
    logic oe, level, busy, done;
    wire  line = host_low ? 1'b0 : (oe ? level : 1'b1);

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic oe;
        logic lvl;
        logic busy;
        logic done;
        int   req;
    } exp_t;

    exp_t expq[$];

    always #5 clk = ~clk;

    sdbg_tx u_sdbg_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line),
        .load_i       (load),
        .bit_i        (bitv),
        .line_oe_o    (oe),
        .line_level_o (level),
        .busy_o       (busy),
        .done_o       (done)
    );

    task automatic push(input logic o, input logic l, input logic b, input logic d, input int r);
        exp_t e;
        e.oe = o; e.lvl = l; e.busy = b; e.done = d; e.req = r;
        expq.push_back(e);
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: one record per clock, 3 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (oe !== e.oe || (e.oe && level !== e.lvl) || busy !== e.busy || done !== e.done) begin
                    errors++;
                    $display("FAIL R%0d got oe=%b lvl=%b busy=%b done=%b expected oe=%b lvl=%b busy=%b done=%b",
                             e.req, oe, level, busy, done, e.oe, e.lvl, e.busy, e.done);
                end
            end
        end
    end

    // bit 1 = logic one; mid_edge adds a host edge during the run (R7),
    // mid_load pulses a load during the run and again in the done cycle (R2)
    task automatic send_bit(input logic b, input bit mid_edge, input bit mid_load);
        int pulse_at;
        pulse_at = b ? 7 : 13;
        @(negedge clk);
        load = 1'b1; bitv = b;
        push(0, 0, 1, 0, 2);                  // R2: busy the cycle after load
        @(negedge clk);
        load = 1'b0;
        host_low = 1'b1;
        push(0, 0, 1, 0, 3);                  // R3: synchronizer latency
        push(0, 0, 1, 0, 3);
        for (int c = 0; c <= pulse_at; c++) begin
            if (c == pulse_at)
                push(1, 1, 1, 0, 8);          // R8: single high pulse
            else if (!b)
                push(1, 0, 1, 0, 5);          // R5: held low
            else
                push(0, 0, 1, 0, 4);          // R4: floating
        end
        push(0, 0, 0, 1, 6);                  // R6: done pulse
        push(0, 0, 0, 0, 6);
        repeat (3) @(negedge clk);
        host_low = 1'b0;
        if (mid_edge) begin
            @(negedge clk);
            host_low = 1'b1;                  // R7: ignored during run
            repeat (2) @(negedge clk);
            host_low = 1'b0;
        end
        if (mid_load) begin
            @(negedge clk);
            load = 1'b1; bitv = ~b;           // R2: ignored while busy
            @(negedge clk);
            load = 1'b0;
            while (done !== 1'b1) @(negedge clk);
            load = 1'b1; bitv = ~b;           // R2: ignored in done cycle
            push(0, 0, 0, 0, 2);
            @(negedge clk);
            load = 1'b0;
        end
        while (expq.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (oe !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1 got oe=%b busy=%b done=%b expected 0 0 0", oe, busy, done);
        end
        rst_n = 1'b1;
        @(negedge clk);

        send_bit(1'b1, 0, 0);
        send_bit(1'b0, 0, 0);
        send_bit(1'b1, 1, 0);
        send_bit(1'b0, 1, 1);
        send_bit(1'b1, 0, 1);

        // R7: host edge with no bit loaded drives nothing
        @(negedge clk);
        host_low = 1'b1;
        for (int i = 0; i < 6; i++) push(0, 0, 0, 0, 7);
        repeat (3) @(negedge clk);
        host_low = 1'b0;
        while (expq.size() > 0) @(negedge clk);

        send_bit(1'b0, 0, 0);
        repeat (2) @(negedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got running expected finished");
        report();
        $finish;
    end
endmodule